// File: doc/BRIEF.md
# Serial Engine Interrupt Status Collector

This unit gathers the event sources of a serial engine and of its transmit and receive FIFOs into a single status word. It masks that word with an enable register and raises one interrupt line. Most sources arrive as single-cycle pulses and are held as sticky bits. Two sources are watermark conditions that the unit computes itself, from the FIFO fill levels and from programmable thresholds.

The sticky bits cover command done, receive-last, cancel completion, abort completion and seven error kinds. They stay set until software clears them. The two watermark bits act as latched levels: a clear removes them only once the condition has gone away. If the condition still holds, the bit sets again at once. This lets an interrupt handler acknowledge every bit it read at the end of its routine without losing a watermark that is still pending.

Software reaches the registers through a simple write port, selected by a 2-bit address:
- address 0 is the enable register;
- address 1 is the write-one-to-clear register;
- address 2 is the transmit threshold;
- address 3 is the receive threshold.

Top module: `irq_stat_unit`

## Requirements
- R1: A one-cycle pulse on bit k of `evt_i` (k = 0..10) sets status bit k at the next clock edge. The bit stays set on later cycles with no pulse until it is cleared.
- R2: A write to address 1 clears every status bit whose data bit is 1 at that edge. Bits written as 0 keep their value.
- R3: When a set source and a clear write hit the same status bit in the same cycle, the bit is 1 after the edge.
- R4: Status bit 11 (transmit watermark) is set at an edge where the transmit threshold is nonzero and `tx_level_i` is less than or equal to it. A clear at an edge where this still holds leaves the bit at 1.
- R5: While the transmit threshold (address 2) is 0, status bit 11 is never set, whatever the transmit level.
- R6: Status bit 12 (receive watermark) is set at an edge where `rx_level_i` is greater than or equal to the receive threshold. A clear at an edge where this still holds leaves the bit at 1.
- R7: A clear of bit 11 or bit 12 at an edge where its condition no longer holds returns that bit to 0.
- R8: `irq_o` is 1 exactly when some status bit and the same bit of the enable register (address 0) are both 1.
- R9: After reset the status word is 0, `irq_o` is 0, the enable register is 0, the transmit threshold is 0 and the receive threshold is 1.
- R10: The sticky sources occupy status bits in this order:
  - bit 0: command done
  - bit 1: receive last
  - bit 2: cancel done
  - bit 3: abort done
  - bit 4: command overrun
  - bit 5: illegal command
  - bit 6: command failure
  - bit 7: RX read error
  - bit 8: RX write error
  - bit 9: TX read error
  - bit 10: TX write error

  Each source sets only its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 11 | Single-cycle event pulses, bit order as in R10 |
| tx_level_i | input | LVL_W (5) | Current transmit FIFO fill level |
| rx_level_i | input | LVL_W (5) | Current receive FIFO fill level |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 enable, 1 clear, 2 TX threshold, 3 RX threshold |
| wr_data_i | input | 13 | Write data; thresholds use the low LVL_W bits |
| status_o | output | 13 | Raw status word |
| irq_o | output | 1 | Interrupt, status AND enable nonzero |

## Verification
The bench targets three situations:
- An event pulse and a clear of the same bit in the same cycle. A design in which the clear wins would lose a completion.
- A clear of a watermark bit while the FIFO level still meets the threshold. A design that treated watermarks as sticky would drop the bit, and the handler would stall.
- A transmit threshold of zero with an empty FIFO. A design using a plain less-or-equal compare would assert the transmit request forever.

It also clears one bit next to another that is set, to catch a clear mask applied to the wrong bits. It checks that the interrupt follows the enable mask bit by bit.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int NUM_STICKY = 11;
    localparam int NUM_SRC    = NUM_STICKY + 2;
    localparam int TXWM_BIT   = NUM_STICKY;
    localparam int RXWM_BIT   = NUM_STICKY + 1;

    // sticky source positions inside the status word
    localparam int SRC_DONE      = 0;
    localparam int SRC_RX_LAST   = 1;
    localparam int SRC_CANCEL    = 2;
    localparam int SRC_ABORT     = 3;
    localparam int SRC_OVERRUN   = 4;
    localparam int SRC_ILLEGAL   = 5;
    localparam int SRC_FAIL      = 6;
    localparam int SRC_RX_RD_ERR = 7;
    localparam int SRC_RX_WR_ERR = 8;
    localparam int SRC_TX_RD_ERR = 9;
    localparam int SRC_TX_WR_ERR = 10;

    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_CLEAR  = 2'd1,
        REG_TX_WM  = 2'd2,
        REG_RX_WM  = 2'd3
    } reg_sel_e;

    typedef logic [NUM_SRC-1:0] stat_word_t;

    // decoded single-cycle write strobes
    typedef struct packed {
        logic en_wr;
        logic clr_wr;
        logic txwm_wr;
        logic rxwm_wr;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_wr(input logic we, input reg_sel_e sel);
        wr_strobe_t s;
        s.en_wr   = we && (sel == REG_ENABLE);
        s.clr_wr  = we && (sel == REG_CLEAR);
        s.txwm_wr = we && (sel == REG_TX_WM);
        s.rxwm_wr = we && (sel == REG_RX_WM);
        return s;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_stat_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    output stat_word_t         enable_o,
    output stat_word_t         clear_o,
    output logic [LVL_W-1:0]   tx_wm_o,
    output logic [LVL_W-1:0]   rx_wm_o
);

    wr_strobe_t stb;
    assign stb = decode_wr(wr_en_i, reg_sel_e'(wr_addr_i));

    // the clear mask acts on the very edge of the write
    assign clear_o = stb.clr_wr ? wr_data_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_o <= '0;
            tx_wm_o  <= '0;
            rx_wm_o  <= LVL_W'(1);
        end else begin
            if (stb.en_wr)   enable_o <= wr_data_i;
            if (stb.txwm_wr) tx_wm_o  <= wr_data_i[LVL_W-1:0];
            if (stb.rxwm_wr) rx_wm_o  <= wr_data_i[LVL_W-1:0];
        end
    end

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $countones({stb.en_wr, stb.clr_wr, stb.txwm_wr, stb.rxwm_wr}) <= 1);

endmodule

// File: rtl/irq_wm_cmp.sv
module irq_wm_cmp #(
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic [LVL_W-1:0] tx_wm_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [LVL_W-1:0] rx_wm_i,
    output logic             tx_hit_o,
    output logic             rx_hit_o
);

    logic tx_enabled;
    assign tx_enabled = |tx_wm_i;

    always_comb begin
        tx_hit_o = tx_enabled && (tx_level_i <= tx_wm_i);
        rx_hit_o = (rx_level_i >= rx_wm_i);
    end

endmodule

// File: rtl/irq_stat_bits.sv
module irq_stat_bits #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)             stat_o[i] <= 1'b0;
            else if (set_i[i])   stat_o[i] <= 1'b1;
            else if (clr_i[i])   stat_o[i] <= 1'b0;
        end

        assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> stat_o[i]);

        assert_clear_takes_R2: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !stat_o[i]);

        assert_held_R1: assert property (@(posedge clk) disable iff (rst)
            (stat_o[i] && !clr_i[i]) |=> stat_o[i]);

        assert_no_spurious_R10: assert property (@(posedge clk) disable iff (rst)
            (!stat_o[i] && !set_i[i]) |=> !stat_o[i]);
    end

endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
    import irq_stat_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_STICKY-1:0] evt_i,
    input  logic [LVL_W-1:0]      tx_level_i,
    input  logic [LVL_W-1:0]      rx_level_i,
    input  logic                  wr_en_i,
    input  logic [1:0]            wr_addr_i,
    input  logic [NUM_SRC-1:0]    wr_data_i,
    output logic [NUM_SRC-1:0]    status_o,
    output logic                  irq_o
);

    stat_word_t       enable_q, clear_w, set_w;
    logic [LVL_W-1:0] tx_wm_q, rx_wm_q;
    logic             tx_hit, rx_hit;

    irq_cfg_regs #(.LVL_W(LVL_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .enable_o  (enable_q),
        .clear_o   (clear_w),
        .tx_wm_o   (tx_wm_q),
        .rx_wm_o   (rx_wm_q)
    );

    irq_wm_cmp #(.LVL_W(LVL_W)) u_cmp (
        .tx_level_i (tx_level_i),
        .tx_wm_i    (tx_wm_q),
        .rx_level_i (rx_level_i),
        .rx_wm_i    (rx_wm_q),
        .tx_hit_o   (tx_hit),
        .rx_hit_o   (rx_hit)
    );

    // sticky sources are pulses; watermark sources are re-evaluated every cycle
    assign set_w = {rx_hit, tx_hit, evt_i};

    irq_stat_bits #(.N(NUM_SRC)) u_bits (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_w),
        .clr_i  (clear_w),
        .stat_o (status_o)
    );

    assign irq_o = |(status_o & enable_q);

    assert_quiet_when_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (status_o == '0) |-> !irq_o);

    assert_tx_wm_off_R5: assert property (@(posedge clk) disable iff (rst)
        ((tx_wm_q == '0) && !status_o[TXWM_BIT]) |=> !status_o[TXWM_BIT]);

    assert_tx_wm_relatch_R4: assert property (@(posedge clk) disable iff (rst)
        ((tx_wm_q != '0) && (tx_level_i <= tx_wm_q)) |=> status_o[TXWM_BIT]);

    assert_rx_wm_relatch_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_level_i >= rx_wm_q) |=> status_o[RXWM_BIT]);

    assert_reset_clean_R9: assert property (@(posedge clk)
        $past(rst) |-> (status_o == '0 && !irq_o));

endmodule

// File: tb/irq_stat_unit_tb.sv
module irq_stat_unit_tb;
    import irq_stat_pkg::*;

    localparam int LW = 5;

    logic                  clk = 1'b0;
    logic                  rst;
    logic [NUM_STICKY-1:0] evt;
    logic [LW-1:0]         txl, rxl;
    logic                  we;
    logic [1:0]            addr;
    logic [NUM_SRC-1:0]    wdata;
    logic [NUM_SRC-1:0]    status;
    logic                  irq;

    always #2.5 clk = ~clk;

    irq_stat_unit #(.FIFO_DEPTH(16)) u_dut (
        .clk(clk), .rst(rst), .evt_i(evt), .tx_level_i(txl), .rx_level_i(rxl),
        .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(wdata),
        .status_o(status), .irq_o(irq)
    );

    typedef struct {
        logic [NUM_SRC-1:0] st;
        logic               ir;
        string              tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // bench reference state built from the requirements
    logic [NUM_SRC-1:0] m_st, m_en;
    logic [LW-1:0]      m_tx, m_rx;

    task automatic cyc(input logic [NUM_STICKY-1:0] e, input logic w, input logic [1:0] a,
                       input logic [NUM_SRC-1:0] d, input logic [LW-1:0] tl,
                       input logic [LW-1:0] rl, input string tag);
        logic [NUM_SRC-1:0] clr, setv;
        logic txc, rxc;
        exp_t x;
        evt = e; we = w; addr = a; wdata = d; txl = tl; rxl = rl;
        clr  = (w && a == 2'd1) ? d : '0;
        txc  = (m_tx != 0) && (tl <= m_tx);
        rxc  = (rl >= m_rx);
        setv = {rxc, txc, e};
        m_st = (m_st & ~clr) | setv;
        if (w && a == 2'd0) m_en = d;
        if (w && a == 2'd2) m_tx = d[LW-1:0];
        if (w && a == 2'd3) m_rx = d[LW-1:0];
        @(posedge clk);
        x.st = m_st; x.ir = |(m_st & m_en); x.tag = tag;
        exp_q.push_back(x);
        @(negedge clk);
        evt = '0; we = 1'b0;
    endtask

    // monitor: compares each expected item on the falling edge after it was pushed
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t x;
                x = exp_q.pop_front();
                n_run++;
                if (status !== x.st || irq !== x.ir) begin
                    n_fail++;
                    $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                             x.tag, status, irq, x.st, x.ir);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; evt = '0; we = 1'b0; addr = '0; wdata = '0; txl = 5'd8; rxl = 5'd0;
        m_st = '0; m_en = '0; m_tx = '0; m_rx = 5'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n_run++;
        if (status !== '0 || irq !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 reset: status=%h irq=%b expected status=0 irq=0", status, irq);
        end
        cyc('0, 0, 0, '0, 8, 0, "R9 thresholds idle after reset");
        cyc(11'h001, 0, 0, '0, 8, 0, "R1 done pulse sets bit0");
        cyc('0, 0, 0, '0, 8, 0, "R1 bit0 held");
        cyc('0, 1, 0, 13'h0001, 8, 0, "R8 enable bit0 raises irq");
        cyc('0, 1, 1, 13'h0002, 8, 0, "R2 clear other bit leaves bit0");
        cyc('0, 1, 1, 13'h0001, 8, 0, "R2 clear bit0");
        cyc(11'h002, 1, 1, 13'h0002, 8, 0, "R3 set wins over clear");
        cyc(11'h004, 0, 0, '0, 8, 0, "R10 cancel bit2");
        cyc(11'h008, 0, 0, '0, 8, 0, "R10 abort bit3");
        cyc(11'h7F0, 0, 0, '0, 8, 0, "R10 error bits 4..10");
        cyc('0, 1, 0, 13'h0008, 8, 0, "R8 enable abort only");
        cyc('0, 1, 1, 13'h0008, 8, 0, "R8 irq drops with abort cleared");
        cyc('0, 1, 1, 13'h1FFF, 8, 0, "R2 clear all");
        cyc('0, 1, 0, 13'h0800, 0, 0, "R5 tx threshold 0 empty fifo");
        cyc('0, 0, 0, '0, 0, 0, "R5 still off");
        cyc('0, 1, 2, 13'h0004, 8, 0, "R4 write tx threshold 4");
        cyc('0, 0, 0, '0, 5, 0, "R4 level above threshold");
        cyc('0, 0, 0, '0, 4, 0, "R4 level equal sets");
        cyc('0, 1, 1, 13'h0800, 4, 0, "R4 clear while held relatches");
        cyc('0, 1, 1, 13'h0800, 9, 0, "R7 tx clear after condition gone");
        cyc('0, 1, 2, 13'h0000, 0, 0, "R5 threshold back to 0");
        cyc('0, 0, 0, '0, 0, 0, "R5 no tx set at level 0");
        cyc('0, 1, 3, 13'h0006, 0, 5, "R6 write rx threshold 6");
        cyc('0, 1, 0, 13'h1000, 0, 6, "R6 rx level equal sets and irq");
        cyc('0, 1, 1, 13'h1000, 0, 7, "R6 clear while held relatches");
        cyc('0, 1, 1, 13'h1000, 0, 5, "R7 rx clear after condition gone");
        cyc('0, 0, 0, '0, 0, 5, "R7 rx stays clear");
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule